// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block keeps the write-protection state of every erasable block in a flash array of 71 blocks: 8 small parameter blocks and 63 main blocks. Each block is in one of three conditions: unlocked, locked, or locked-down. A command front end passes in bus write cycles that have already been reduced to an 8-bit code and a block index. The block recognises the two-cycle protection sequences within them: a setup write of 60h, then a confirm write. The confirm write is 01h to lock, D0h to unlock, or 2Fh to lock down.

Two synchronised pins also act on the state. A device reset pin returns every block to locked when it is released. A write-protect pin decides whether the locked-down condition is enforced. The rest of the chip asks three kinds of question, and each answer comes back one clock later:

- whether a block may be written;
- whether a program or erase request is granted or refused, with a sticky lock-error flag for the status register;
- the two-bit lock status of a block, for identification reads.

Top module: `flash_lock_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, every block reads as locked and not locked-down (`id_status` = 01h), `chk_writable` is 0, and `lock_err`, `op_grant`, `op_refuse` and `seq_fallback` are 0.
- R2: A write of 60h followed, on the next write cycle, by 01h (lock) or D0h (unlock) changes the block whose index accompanies the confirm write. The new state is visible to a query presented in the cycle after the confirm write.
- R3: A 60h write followed by a 2Fh write sets both the locked and the locked-down condition of the target block.
- R4: An unlock confirm has no effect on a locked-down block while `wp_pin` is 0. While `wp_pin` is 1 it clears the locked condition, and the locked-down flag stays set.
- R5: When the write after a 60h setup is not 01h, D0h or 2Fh, no block changes. `seq_fallback` is high for exactly the one cycle after that write, and the sequence is abandoned: a later lone confirm code does nothing.
- R6: While `rst_pin_n` is 0, command writes and program/erase requests are ignored (no grant and no refuse). On the clock edge where `rst_pin_n` is first seen high again, every block becomes locked and every locked-down flag is cleared.
- R7: A request on `op_req` gives `op_grant` one cycle later if the block is unlocked. Otherwise it gives `op_refuse` and sets `lock_err`. `lock_err` stays set until `err_clr`, and a refusal in the same cycle as `err_clr` wins.
- R8: `id_status` bit 0 is the locked condition and bit 1 the locked-down flag of block `id_blk`; bits 7..2 are 0. Any index of 71 or more reads 00h, is reported not writable, and has its program/erase requests refused.
- R9: `chk_writable` is 1 exactly when block `chk_blk` is unlocked, one cycle after the index is presented.
- R10: Cycles with `wr_en` low are not command writes, and a confirm code written without a preceding 60h changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Synchronised device reset pin, low = reset |
| wp_pin | input | 1 | Synchronised write-protect pin, low = lock-down enforced |
| wr_en | input | 1 | Command write cycle strobe |
| wr_data | input | 8 | Command code of the write cycle |
| wr_blk | input | 7 | Block index of the write cycle |
| seq_fallback | output | 1 | Pulse: protection sequence abandoned, bank returns to status read |
| chk_blk | input | 7 | Block index for the writability query |
| chk_writable | output | 1 | Queried block may be programmed or erased |
| op_req | input | 1 | Program or erase request |
| op_blk | input | 7 | Target block of the request |
| op_grant | output | 1 | Request accepted |
| op_refuse | output | 1 | Request refused because of protection |
| err_clr | input | 1 | Clear the lock-error flag |
| lock_err | output | 1 | Sticky lock-error flag |
| id_blk | input | 7 | Block index for the lock status read |
| id_status | output | 8 | Lock status byte of the indexed block |

## Verification
Every output of this block is a register. A query, request or write sampled at one rising edge is therefore answered in the cycle that follows it. A protection change made by a confirm write becomes visible to a query presented in the next cycle, and so appears one further edge later. The same holds for the blanket lock caused by releasing the reset pin. The bench drives inputs just after a falling edge, lets exactly one rising edge pass, and compares at the next falling edge against a per-block model. A query about a new state is presented only in the cycle after the write or release that caused it, so no check samples a value while it is still changing.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam logic [7:0] CODE_SETUP  = 8'h60;
    localparam logic [7:0] CODE_LOCK   = 8'h01;
    localparam logic [7:0] CODE_UNLOCK = 8'hD0;
    localparam logic [7:0] CODE_DOWN   = 8'h2F;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOCK   = 2'd1,
        ACT_UNLOCK = 2'd2,
        ACT_DOWN   = 2'd3
    } lk_act_e;

    typedef struct packed {
        logic down;
        logic locked;
    } lk_state_t;

    localparam lk_state_t LK_AFTER_RESET = '{down: 1'b0, locked: 1'b1};

    // Map a confirm-cycle code to an action; ACT_NONE marks an invalid confirm.
    function automatic lk_act_e decode_confirm(input logic [7:0] code);
        lk_act_e a;
        case (code)
            CODE_LOCK:   a = ACT_LOCK;
            CODE_UNLOCK: a = ACT_UNLOCK;
            CODE_DOWN:   a = ACT_DOWN;
            default:     a = ACT_NONE;
        endcase
        return a;
    endfunction

    // Protection transition for one block. The down flag is enforced only
    // while the write-protect pin is low.
    function automatic lk_state_t next_state(input lk_state_t cur,
                                             input lk_act_e   act,
                                             input logic      wp_pin);
        lk_state_t n;
        n = cur;
        case (act)
            ACT_LOCK: n.locked = 1'b1;
            ACT_DOWN: begin
                n.locked = 1'b1;
                n.down   = 1'b1;
            end
            ACT_UNLOCK: begin
                if (!(cur.down && !wp_pin)) n.locked = 1'b0;
            end
            default: ;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] pack_status(input lk_state_t s);
        return {6'b0, s.down, s.locked};
    endfunction

endpackage

// File: rtl/flk_cmd_seq.sv
module flk_cmd_seq
    import flk_pkg::*;
#(
    parameter int BLK_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] wr_blk,
    output lk_act_e          act,
    output logic [BLK_W-1:0] act_blk,
    output logic             fallback
);

    logic armed_q;
    logic bad_confirm;

    always_comb begin
        act         = ACT_NONE;
        act_blk     = wr_blk;
        bad_confirm = 1'b0;
        if (active && wr_en && armed_q) begin
            act         = decode_confirm(wr_data);
            bad_confirm = (act == ACT_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            armed_q  <= 1'b0;
            fallback <= 1'b0;
        end else begin
            fallback <= bad_confirm;
            if (wr_en) armed_q <= !armed_q && (wr_data == CODE_SETUP);
        end
    end

endmodule

// File: rtl/flk_cell.sv
module flk_cell
    import flk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      release_all,
    input  logic      sel,
    input  lk_act_e   act,
    input  logic      wp_pin,
    output lk_state_t state
);

    always_ff @(posedge clk) begin
        if (rst || release_all) state <= LK_AFTER_RESET;
        else if (sel)           state <= next_state(state, act, wp_pin);
    end

endmodule

// File: rtl/flk_array.sv
module flk_array
    import flk_pkg::*;
#(
    parameter int NUM_BLOCKS = 71,
    parameter int BLK_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  release_all,
    input  lk_act_e               act,
    input  logic [BLK_W-1:0]      act_blk,
    input  logic                  wp_pin,
    output logic [NUM_BLOCKS-1:0] locked_vec,
    output logic [NUM_BLOCKS-1:0] down_vec
);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        lk_state_t st;
        logic      hit;
        assign hit = (act != ACT_NONE) && (act_blk == BLK_W'(i));
        flk_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .release_all (release_all),
            .sel         (hit),
            .act         (act),
            .wp_pin      (wp_pin),
            .state       (st)
        );
        assign locked_vec[i] = st.locked;
        assign down_vec[i]   = st.down;
    end

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NUM_BLOCKS = 71,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin_n,
    input  logic             wp_pin,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] wr_blk,
    output logic             seq_fallback,
    input  logic [BLK_W-1:0] chk_blk,
    output logic             chk_writable,
    input  logic             op_req,
    input  logic [BLK_W-1:0] op_blk,
    output logic             op_grant,
    output logic             op_refuse,
    input  logic             err_clr,
    output logic             lock_err,
    input  logic [BLK_W-1:0] id_blk,
    output logic [7:0]       id_status
);

    localparam int SPAN = 1 << BLK_W;

    logic                  pin_q;
    logic                  release_all;
    lk_act_e               act;
    logic [BLK_W-1:0]      act_blk;
    logic [NUM_BLOCKS-1:0] locked_vec;
    logic [NUM_BLOCKS-1:0] down_vec;
    logic [SPAN-1:0]       lk_ext;
    logic [SPAN-1:0]       dn_ext;
    logic                  op_ok;
    logic                  refuse_now;
    lk_state_t             id_st;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= rst_pin_n;
    end
    assign release_all = rst_pin_n && !pin_q;

    flk_cmd_seq #(.BLK_W(BLK_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .active   (rst_pin_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_blk   (wr_blk),
        .act      (act),
        .act_blk  (act_blk),
        .fallback (seq_fallback)
    );

    flk_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_array (
        .clk         (clk),
        .rst         (rst),
        .release_all (release_all),
        .act         (act),
        .act_blk     (act_blk),
        .wp_pin      (wp_pin),
        .locked_vec  (locked_vec),
        .down_vec    (down_vec)
    );

    // Indices past the last block read as locked and not down.
    always_comb begin
        lk_ext = '1;
        dn_ext = '0;
        lk_ext[NUM_BLOCKS-1:0] = locked_vec;
        dn_ext[NUM_BLOCKS-1:0] = down_vec;
    end

    assign op_ok      = (int'(op_blk) < NUM_BLOCKS) && !lk_ext[op_blk];
    assign refuse_now = rst_pin_n && op_req && !op_ok;
    assign id_st      = '{down: dn_ext[id_blk], locked: lk_ext[id_blk]};

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_writable <= 1'b0;
            op_grant     <= 1'b0;
            op_refuse    <= 1'b0;
            lock_err     <= 1'b0;
            id_status    <= 8'h00;
        end else begin
            chk_writable <= (int'(chk_blk) < NUM_BLOCKS) && !lk_ext[chk_blk];
            id_status    <= (int'(id_blk) < NUM_BLOCKS) ? pack_status(id_st) : 8'h00;
            op_grant     <= rst_pin_n && op_req && op_ok;
            op_refuse    <= refuse_now;
            if (refuse_now)   lock_err <= 1'b1;
            else if (err_clr) lock_err <= 1'b0;
        end
    end

endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
    parameter int BLK_W = 7
) (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin_n,
    input logic       seq_fallback,
    input logic       op_req,
    input logic       op_grant,
    input logic       op_refuse,
    input logic       err_clr,
    input logic       lock_err,
    input logic [7:0] id_status
);

    p_grant_refuse_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(op_grant && op_refuse));

    p_refuse_sets_err_r7: assert property (@(posedge clk) disable iff (rst)
        op_refuse |-> lock_err);

    p_err_clears_only_on_request_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_err) |-> $past(err_clr));

    p_answer_needs_request_r7: assert property (@(posedge clk) disable iff (rst)
        (op_grant || op_refuse) |-> $past(op_req));

    p_pin_reset_blocks_ops_r6: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> !(op_grant || op_refuse));

    p_fallback_single_r5: assert property (@(posedge clk) disable iff (rst)
        seq_fallback |=> !seq_fallback);

    p_status_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        id_status[7:2] == 6'b0);

endmodule

bind flash_lock_ctrl flk_checker #(.BLK_W(BLK_W)) u_flk_chk (
    .clk          (clk),
    .rst          (rst),
    .rst_pin_n    (rst_pin_n),
    .seq_fallback (seq_fallback),
    .op_req       (op_req),
    .op_grant     (op_grant),
    .op_refuse    (op_refuse),
    .err_clr      (err_clr),
    .lock_err     (lock_err),
    .id_status    (id_status)
);

// File: tb/flash_lock_ctrl_bench.sv
`timescale 1ns/1ps
module flash_lock_ctrl_bench;

    localparam int NB = 71;
    localparam int BW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rst_pin_n = 1'b1;
    logic          wp_pin = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [BW-1:0] wr_blk = '0;
    logic          seq_fallback;
    logic [BW-1:0] chk_blk = '0;
    logic          chk_writable;
    logic          op_req = 1'b0;
    logic [BW-1:0] op_blk = '0;
    logic          op_grant;
    logic          op_refuse;
    logic          err_clr = 1'b0;
    logic          lock_err;
    logic [BW-1:0] id_blk = '0;
    logic [7:0]    id_status;

    always #10 clk = ~clk;

    flash_lock_ctrl u_flash_lock_ctrl (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit m_lock [NB];
    bit m_down [NB];
    bit m_err;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void m_reset_all();
        for (int i = 0; i < NB; i++) begin
            m_lock[i] = 1'b1;
            m_down[i] = 1'b0;
        end
    endfunction

    function automatic bit m_bad(input logic [7:0] code);
        return !(code == 8'h01 || code == 8'hD0 || code == 8'h2F);
    endfunction

    function automatic void m_apply(input logic [7:0] code, input int b);
        if (b >= NB) return;
        case (code)
            8'h01: m_lock[b] = 1'b1;
            8'h2F: begin m_lock[b] = 1'b1; m_down[b] = 1'b1; end
            8'hD0: if (!(m_down[b] && !wp_pin)) m_lock[b] = 1'b0;
            default: ;
        endcase
    endfunction

    function automatic int m_status(input int b);
        if (b >= NB) return 0;
        return {m_down[b], m_lock[b]};
    endfunction

    function automatic int m_writable(input int b);
        if (b >= NB) return 0;
        return m_lock[b] ? 0 : 1;
    endfunction

    task automatic write_cycle(input logic [7:0] d, input int b);
        wr_en = 1'b1; wr_data = d; wr_blk = BW'(b);
        step();
        wr_en = 1'b0;
    endtask

    // Two-cycle protection command: R2 / R3 / R4 / R5
    task automatic cmd(input logic [7:0] code, input int b);
        write_cycle(8'h60, b);
        check("R5 no fallback on setup", seq_fallback, 0);
        write_cycle(code, b);
        m_apply(code, b);
        check("R5 fallback pulse after confirm", seq_fallback, m_bad(code));
    endtask

    task automatic probe(input string req, input int b);
        id_blk = BW'(b); chk_blk = BW'(b);
        step();
        check({req, " id_status"}, id_status, m_status(b));
        check({"R9 ", req, " chk_writable"}, chk_writable, m_writable(b));
    endtask

    task automatic op(input int b, input bit clr);
        bit g;
        op_req = 1'b1; op_blk = BW'(b); err_clr = clr;
        step();
        op_req = 1'b0; err_clr = 1'b0;
        g = (m_writable(b) == 1);
        if (!g) m_err = 1'b1;
        else if (clr) m_err = 1'b0;
        check("R7 op_grant", op_grant, g);
        check("R7 op_refuse", op_refuse, !g);
        check("R7 lock_err", lock_err, m_err);
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        m_err = 1'b0;
        check("R7 lock_err cleared", lock_err, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_reset_all();
        m_err = 1'b0;
        @(negedge clk);
        step();
        // R1 during reset
        check("R1 lock_err in reset", lock_err, 0);
        check("R1 op_grant in reset", op_grant, 0);
        check("R1 fallback in reset", seq_fallback, 0);
        step();
        rst = 1'b0;
        step();
        for (int b = 0; b < NB; b++) probe("R1 after reset", b);
        check("R1 op_refuse idle", op_refuse, 0);

        // R2 unlock then relock
        cmd(8'hD0, 3);
        probe("R2 unlocked", 3);
        probe("R2 neighbour stays", 4);
        op(3, 1'b0);
        cmd(8'h01, 3);
        probe("R2 relocked", 3);

        // R3 / R4 lock-down with wp low, then wp high
        wp_pin = 1'b0;
        cmd(8'h2F, 10);
        probe("R3 down set", 10);
        cmd(8'hD0, 10);
        probe("R4 unlock ignored when down", 10);
        wp_pin = 1'b1;
        cmd(8'hD0, 10);
        probe("R4 unlock with wp high", 10);
        wp_pin = 1'b0;
        cmd(8'h01, 10);
        probe("R4 relock keeps down flag", 10);

        // R5 bad confirm
        cmd(8'hD0, 20);
        cmd(8'h55, 20);
        step();
        check("R5 fallback single cycle", seq_fallback, 0);
        write_cycle(8'h01, 20);
        probe("R5 lone confirm ignored", 20);

        // R10 strobe low and lone confirm
        wr_en = 1'b0; wr_data = 8'h60; wr_blk = BW'(20);
        step();
        write_cycle(8'h01, 20);
        probe("R10 strobe-low setup ignored", 20);
        write_cycle(8'hD0, 0);
        probe("R10 lone unlock ignored", 0);

        // R7 refusal, stickiness, clear, same-cycle priority
        op(0, 1'b0);
        op(20, 1'b0);
        check("R7 lock_err sticky", lock_err, 1);
        op(5, 1'b1);
        clear_err();

        // R8 out-of-range indices
        probe("R8 index 71", 71);
        probe("R8 index 127", 127);
        op(100, 1'b0);
        clear_err();

        // R6 reset pin
        cmd(8'hD0, 30);
        cmd(8'h2F, 31);
        rst_pin_n = 1'b0;
        step();
        write_cycle(8'h60, 40);
        write_cycle(8'hD0, 40);
        op_req = 1'b1; op_blk = BW'(30);
        step();
        op_req = 1'b0;
        check("R6 no grant during pin reset", op_grant, 0);
        check("R6 no refuse during pin reset", op_refuse, 0);
        rst_pin_n = 1'b1;
        step();
        m_reset_all();
        probe("R6 release relocks", 30);
        probe("R6 release clears down", 31);
        probe("R6 write ignored in pin reset", 40);
        probe("R6 down block after release", 10);
        wp_pin = 1'b0;
        cmd(8'hD0, 31);
        probe("R6 unlock works after down cleared", 31);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int sel;
            int b;
            sel = $urandom_range(0, 9);
            b   = (($urandom_range(0, 15)) == 0) ? $urandom_range(NB, 127) : $urandom_range(0, NB - 1);
            case (sel)
                0, 1: cmd(8'hD0, b);
                2:    cmd(8'h01, b);
                3:    cmd(8'h2F, b);
                4: begin
                    logic [7:0] c;
                    c = 8'($urandom_range(0, 255));
                    cmd(c, b);
                end
                5:    wp_pin = ~wp_pin;
                6:    op(b, $urandom_range(0, 3) == 0);
                7:    clear_err();
                default: probe("R2 random", b);
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule